// File: doc/BRIEF.md
# Letterboxed Pixel-Doubling Video Scanner

This block produces a 1024x768 raster from a 65 MHz pixel clock and shows a 512x342 monochrome bitmap inside it at double size. Each stored bit appears as a 2x2 square, so the picture fills 1024x684. The spare 84 lines are split evenly into black bands, 42 lines above the picture and 42 below. The outputs are active-low horizontal and vertical sync and one video bit that drives all three colour channels together.

The bitmap is held in an external 32Kx8 asynchronous SRAM. Each stored row is 64 bytes long, and the block reads one byte for every 16 output pixels. Each read uses a fixed two-clock window inside the 16-clock byte period. Every other clock is left free for a write that a neighbouring snoop unit requests. The first byte of each picture line is read at the end of the line before it, so the leftmost pixel is on time.

Top module: `lbx_scanner`

## Requirements
- R1: A line lasts 1344 clocks (1024 visible, then 24 front porch, 136 sync, 160 back porch). hsync_n is low for exactly the 136 sync clocks that start at line position 1048.
- R2: A frame lasts 806 lines (768 visible, then 3 front porch, 6 sync, 29 back porch). vsync_n is low throughout lines 771 to 776.
- R3: video is 0 (black) at every line position of 1024 or higher.
- R4: video is 0 on the letterbox lines. These are the first (V_ACTIVE-2*SRC_LINES)/2 visible lines (42 by default) and all visible lines after the 2*SRC_LINES picture lines.
- R5: At picture line v and pixel h, with top = 42, video shows bit 7-((h mod 16)/2) of the byte at SRAM address ((v-top)/2)*64 + h/16. The bits go out MSB first, each on two adjacent pixels and on two adjacent lines. A stored 1 gives video 0 and a stored 0 gives video 1.
- R6: ram_oe_n is low only in slots 8 and 9 of a 16-clock byte period (slot = line position mod 16). While it is low, ram_ce_n is low and ram_addr holds steady. A read happens only when a picture byte is needed.
- R7: While wr_req is high, the block writes wr_data to wr_addr in the first free clock: ram_we_n and ram_ce_n are low, ram_dq_oe is high and wr_done is high for that one clock. Measured from the edge at which wr_req is first sampled, wr_done is high 1 clock later if that clock is free, and 2 or 3 clocks later if the request is made just before or during a read window.
- R8: ram_oe_n and ram_we_n are never low together, and ram_ce_n is low whenever either of them is low.
- R9: The first picture byte of a line is fetched before the line starts. Pixels 0 and 1 of each picture line already show bit 7 of column 0.
- R10: While rst is high: hsync_n and vsync_n are 1, video is 0, all SRAM strobes are high, ram_dq_oe is 0 and wr_done is 0. After rst is released, the outputs following the n-th rising edge describe raster position n-1, where position 0 is pixel 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_req | input | 1 | Write request, held until wr_done |
| wr_addr | input | 15 | Write byte address |
| wr_data | input | 8 | Write byte |
| ram_dq_i | input | 8 | Data read from the SRAM |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| video | output | 1 | Monochrome pixel, 1 = white |
| wr_done | output | 1 | High in the clock the write takes place |
| ram_addr | output | 15 | SRAM address |
| ram_dq_o | output | 8 | Data driven to the SRAM |
| ram_dq_oe | output | 1 | Enable for the data driver |
| ram_ce_n | output | 1 | SRAM chip enable, active low |
| ram_oe_n | output | 1 | SRAM output enable, active low |
| ram_we_n | output | 1 | SRAM write enable, active low |

## Verification
hsync_n, vsync_n and video each lag the raster position they describe by one register. The bench counts rising edges from reset release, turns that count into a position, and compares all three outputs on the falling edge of the same clock. A write grant is due 1, 2 or 3 clocks after the edge that samples the request, depending on the byte-period slot and on whether a fetch is pending. The bench raises wr_req at a known position, counts the falling edges until wr_done, and checks that number against the expected latency. The bench SRAM returns data in the clock after ram_oe_n falls, and written bytes are recorded from the strobes. This lets later frames show the written values in place.

// File: rtl/lbx_pkg.sv
package lbx_pkg;
  localparam int BYTE_BITS     = 8;
  localparam int PIX_REPEAT    = 2;
  localparam int CLKS_PER_BYTE = BYTE_BITS * PIX_REPEAT;

  // true when pos lies in [first, first+count)
  function automatic logic in_window(int pos, int first, int count);
    return (pos >= first) && (pos < first + count);
  endfunction

  // stored row shown on output line 'line' below a band of 'top' lines
  function automatic int src_row(int line, int top);
    return (line - top) / PIX_REPEAT;
  endfunction

  function automatic int byte_addr(int row, int col, int row_bytes);
    return row * row_bytes + col;
  endfunction
endpackage

// File: rtl/lbx_raster.sv
module lbx_raster #(
  parameter int H_ACTIVE = 1024,
  parameter int H_FP     = 24,
  parameter int H_SYNC   = 136,
  parameter int H_BP     = 160,
  parameter int V_ACTIVE = 768,
  parameter int V_FP     = 3,
  parameter int V_SYNC   = 6,
  parameter int V_BP     = 29,
  parameter int HW       = 11,
  parameter int VW       = 10
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic          hsync_n,
  output logic          vsync_n
);
  import lbx_pkg::*;

  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam logic [HW-1:0] H_LAST  = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST  = VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] HS_SEEN = HW'(H_ACTIVE + H_FP + 1);
  localparam logic [VW-1:0] VS_LINE = VW'(V_ACTIVE + V_FP);

  logic line_end, hs_zone, vs_zone;
  assign line_end = (hcnt == H_LAST);
  assign hs_zone  = in_window(int'(hcnt), H_ACTIVE + H_FP, H_SYNC);
  assign vs_zone  = in_window(int'(vcnt), V_ACTIVE + V_FP, V_SYNC);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt    <= '0;
      vcnt    <= '0;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
    end else begin
      hcnt <= line_end ? '0 : hcnt + 1'b1;
      if (line_end) vcnt <= (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
      hsync_n <= !hs_zone;
      vsync_n <= !vs_zone;
    end
  end

  // R1: sync pulse begins right after position 1048 was shown
  assert_hsync_start_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync_n) |-> hcnt == HS_SEEN);
  // R2: vertical pulse begins on the first clock of line 771
  assert_vsync_start_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(vsync_n) |-> (vcnt == VS_LINE) && (hcnt == HW'(1)));
endmodule

// File: rtl/lbx_fetch.sv
module lbx_fetch #(
  parameter int H_TOTAL   = 1344,
  parameter int V_TOTAL   = 806,
  parameter int H_ACTIVE  = 1024,
  parameter int V_ACTIVE  = 768,
  parameter int SRC_LINES = 342,
  parameter int RD_SLOT   = 8,
  parameter int AW        = 15,
  parameter int HW        = 11,
  parameter int VW        = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [7:0]    ram_dq_i,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_dq_o,
  output logic          ram_dq_oe,
  output logic          ram_ce_n,
  output logic          ram_oe_n,
  output logic          ram_we_n,
  output logic          wr_done,
  output logic [7:0]    fetch_byte
);
  import lbx_pkg::*;

  localparam int PERIODS   = H_TOTAL / CLKS_PER_BYTE;
  localparam int COLS      = H_ACTIVE / CLKS_PER_BYTE;
  localparam int IMG_LINES = PIX_REPEAT * SRC_LINES;
  localparam int TOP       = (V_ACTIVE - IMG_LINES) / 2;

  int period, col_nx, line_nx, slot_nx, slot_now;
  logic need, rd_go, wr_go, capture;
  logic [AW-1:0] rd_addr;

  always_comb begin
    period   = int'(hcnt) / CLKS_PER_BYTE;
    slot_nx  = (int'(hcnt) + 1) % CLKS_PER_BYTE;
    slot_now = int'(hcnt) % CLKS_PER_BYTE;
    if (period == PERIODS - 1) begin
      col_nx  = 0;
      line_nx = (int'(vcnt) == V_TOTAL - 1) ? 0 : int'(vcnt) + 1;
    end else begin
      col_nx  = period + 1;
      line_nx = int'(vcnt);
    end
    need    = (col_nx < COLS) && in_window(line_nx, TOP, IMG_LINES);
    rd_go   = need && (slot_nx == RD_SLOT || slot_nx == RD_SLOT + 1);
    rd_addr = AW'(byte_addr(src_row(line_nx, TOP), col_nx, COLS));
    wr_go   = wr_req && !rd_go && !wr_done;
    capture = !ram_oe_n && (slot_now == RD_SLOT + 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr   <= '0;
      ram_dq_o   <= '0;
      ram_dq_oe  <= 1'b0;
      ram_ce_n   <= 1'b1;
      ram_oe_n   <= 1'b1;
      ram_we_n   <= 1'b1;
      wr_done    <= 1'b0;
      fetch_byte <= '0;
    end else begin
      ram_oe_n  <= !rd_go;
      ram_we_n  <= !wr_go;
      ram_ce_n  <= !(rd_go || wr_go);
      ram_dq_oe <= wr_go;
      wr_done   <= wr_go;
      if (rd_go)      ram_addr <= rd_addr;
      else if (wr_go) ram_addr <= wr_addr;
      if (wr_go)      ram_dq_o <= wr_data;
      if (capture)    fetch_byte <= ram_dq_i;
    end
  end

  // R6: reads stay inside their fixed slot pair with a steady address
  assert_rd_slot_R6: assert property (@(posedge clk) disable iff (rst)
    !ram_oe_n |-> (slot_now == RD_SLOT) || (slot_now == RD_SLOT + 1));
  assert_rd_addr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!ram_oe_n && $past(!ram_oe_n)) |-> $stable(ram_addr));
  // R8: strobes never collide and chip enable covers both
  assert_bus_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(!ram_oe_n && !ram_we_n));
  assert_ce_cover_R8: assert property (@(posedge clk) disable iff (rst)
    (!ram_oe_n || !ram_we_n) |-> !ram_ce_n);
  // R7: a write lasts one clock
  assert_wr_single_R7: assert property (@(posedge clk) disable iff (rst)
    wr_done |=> !wr_done);
endmodule

// File: rtl/lbx_shifter.sv
module lbx_shifter #(
  parameter int H_ACTIVE  = 1024,
  parameter int V_ACTIVE  = 768,
  parameter int SRC_LINES = 342,
  parameter int HW        = 11,
  parameter int VW        = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  input  logic [7:0]    fetch_byte,
  output logic          video
);
  import lbx_pkg::*;

  localparam int IMG_LINES = PIX_REPEAT * SRC_LINES;
  localparam int TOP       = (V_ACTIVE - IMG_LINES) / 2;
  localparam logic [HW-1:0] H_ACT_L = HW'(H_ACTIVE);

  logic [7:0] sr;
  logic load, shift, pixel_on;

  assign load     = (int'(hcnt) % CLKS_PER_BYTE) == CLKS_PER_BYTE - 1;
  assign shift    = hcnt[0] && !load;
  assign pixel_on = (int'(hcnt) < H_ACTIVE) && in_window(int'(vcnt), TOP, IMG_LINES);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr    <= '0;
      video <= 1'b0;
    end else begin
      if (load)       sr <= fetch_byte;
      else if (shift) sr <= {sr[6:0], 1'b0};
      video <= pixel_on && !sr[7];
    end
  end

  // R3: light pixels only come from visible line positions
  assert_black_blank_R3: assert property (@(posedge clk) disable iff (rst)
    video |-> $past(hcnt) < H_ACT_L);
endmodule

// File: rtl/lbx_scanner.sv
module lbx_scanner #(
  parameter int H_ACTIVE  = 1024,
  parameter int H_FP      = 24,
  parameter int H_SYNC    = 136,
  parameter int H_BP      = 160,
  parameter int V_ACTIVE  = 768,
  parameter int V_FP      = 3,
  parameter int V_SYNC    = 6,
  parameter int V_BP      = 29,
  parameter int SRC_LINES = 342,
  parameter int RD_SLOT   = 8,
  parameter int AW        = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [7:0]    ram_dq_i,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          video,
  output logic          wr_done,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_dq_o,
  output logic          ram_dq_oe,
  output logic          ram_ce_n,
  output logic          ram_oe_n,
  output logic          ram_we_n
);
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int VW      = $clog2(V_TOTAL);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [7:0]    fetch_byte;

  lbx_raster #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .HW(HW), .VW(VW)
  ) u_raster (
    .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt),
    .hsync_n(hsync_n), .vsync_n(vsync_n)
  );

  lbx_fetch #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .H_ACTIVE(H_ACTIVE),
    .V_ACTIVE(V_ACTIVE), .SRC_LINES(SRC_LINES), .RD_SLOT(RD_SLOT),
    .AW(AW), .HW(HW), .VW(VW)
  ) u_fetch (
    .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .ram_dq_i(ram_dq_i), .ram_addr(ram_addr), .ram_dq_o(ram_dq_o),
    .ram_dq_oe(ram_dq_oe), .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n),
    .ram_we_n(ram_we_n), .wr_done(wr_done), .fetch_byte(fetch_byte)
  );

  lbx_shifter #(
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .SRC_LINES(SRC_LINES),
    .HW(HW), .VW(VW)
  ) u_shift (
    .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt),
    .fetch_byte(fetch_byte), .video(video)
  );
endmodule

// File: tb/sim_lbx_scanner.sv
module sim_lbx_scanner;
  // shortened frame: 40 visible lines, 16 stored rows, 4-line bands
  localparam int HA = 1024, HT = 1344, HS0 = 1048, HSN = 136;
  localparam int VA = 40, VFP = 3, VSN = 6, VBP = 29, SRC = 16;
  localparam int VT = VA + VFP + VSN + VBP;
  localparam int IMG = 2 * SRC;
  localparam int TOP = (VA - IMG) / 2;
  localparam int NV = 9;
  // line, position, address, data, expected grant latency
  localparam int VEC [NV][5] = '{
    '{1,   87, 193, 8'hAA, 1},
    '{1,  100, 192, 8'hF0, 1},
    '{1,  300, 255, 8'h0F, 1},
    '{8,   87,   0, 8'h81, 3},
    '{8,  104,   5, 8'h3C, 2},
    '{8,  115,  63, 8'hFF, 1},
    '{8, 1015,  65, 8'h18, 1},
    '{8, 1127,  64, 8'h00, 1},
    '{8, 1335, 127, 8'h55, 3}
  };

  logic clk = 1'b0, rst = 1'b1, wr_req = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0, ram_dq_i = '0;
  logic hsync_n, vsync_n, video, wr_done, ram_dq_oe, ram_ce_n, ram_oe_n, ram_we_n;
  logic [14:0] ram_addr;
  logic [7:0]  ram_dq_o;
  int k = 0, n_cmp = 0, n_bad = 0, wn = 0;
  bit run_chk = 1'b0;
  logic [14:0] wa [16];
  logic [7:0]  wd [16];

  always #2 clk = ~clk;

  lbx_scanner #(.V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VSN), .V_BP(VBP), .SRC_LINES(SRC)) u0 (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .ram_dq_i(ram_dq_i), .hsync_n(hsync_n), .vsync_n(vsync_n), .video(video),
    .wr_done(wr_done), .ram_addr(ram_addr), .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe),
    .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n)
  );

  always @(posedge clk) k <= rst ? 0 : k + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_rd(input logic [14:0] a);
    logic [14:0] t;
    logic [7:0] r;
    t = a * 15'd13;
    r = t[7:0] ^ a[12:5];
    for (int i = 0; i < wn; i++) if (wa[i] == a) r = wd[i];
    return r;
  endfunction

  // SRAM model: data valid in the clock after the read strobe falls
  always @(negedge clk) begin
    if (!rst) begin
      if (!ram_oe_n) ram_dq_i <= mem_rd(ram_addr);
      if (!ram_we_n && wn < 16) begin
        wa[wn] <= ram_addr;
        wd[wn] <= ram_dq_o;
        wn <= wn + 1;
      end
    end
  end

  // per-clock comparison against the raster position one clock back
  always @(negedge clk) begin
    if (!rst && run_chk && k >= 1) begin
      int p, h, v, row, slot;
      logic [7:0] b;
      logic ev;
      string tg;
      p = k - 1;
      h = p % HT;
      v = (p / HT) % VT;
      check(hsync_n == !(h >= HS0 && h < HS0 + HSN), "R1", "hsync_n", hsync_n, !(h >= HS0 && h < HS0 + HSN));
      check(vsync_n == !(v >= VA + VFP && v < VA + VFP + VSN), "R2", "vsync_n", vsync_n, !(v >= VA + VFP && v < VA + VFP + VSN));
      ev = 1'b0;
      if (h >= HA) tg = "R3";
      else if (v < TOP || v >= TOP + IMG) tg = "R4";
      else begin
        row = (v - TOP) >> 1;
        b = mem_rd(15'(row * 64 + h / 16));
        ev = !b[7 - ((h % 16) >> 1)];
        tg = (h < 16) ? "R9" : "R5";
      end
      check(video == ev, tg, "video", video, ev);
      check(!(!ram_oe_n && !ram_we_n) && ((ram_oe_n && ram_we_n) || !ram_ce_n), "R8", "strobes", {ram_ce_n, ram_oe_n, ram_we_n}, 0);
      if (!ram_oe_n) begin
        slot = (k % HT) % 16;
        check(slot == 8 || slot == 9, "R6", "read slot", slot, 8);
      end
    end
  end

  task automatic check_reset_state();
    check(hsync_n && vsync_n, "R10", "syncs in reset", {hsync_n, vsync_n}, 3);
    check(video == 1'b0, "R10", "video in reset", video, 0);
    check(ram_ce_n && ram_oe_n && ram_we_n, "R10", "strobes in reset", {ram_ce_n, ram_oe_n, ram_we_n}, 7);
    check(!wr_done && !ram_dq_oe, "R10", "write side in reset", {wr_done, ram_dq_oe}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    run_chk = 1'b1;
    // write vectors: grant latency and bus values
    for (int i = 0; i < NV; i++) begin
      int n;
      while (k != VEC[i][0] * HT + VEC[i][1]) @(negedge clk);
      wr_addr = 15'(VEC[i][2]);
      wr_data = 8'(VEC[i][3]);
      wr_req = 1'b1;
      n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (!wr_done && n < 8);
      check(n == VEC[i][4], "R7", "grant latency", n, VEC[i][4]);
      check(ram_addr == wr_addr && ram_dq_o == wr_data && ram_dq_oe && !ram_we_n,
            "R7", "write bus", ram_addr, wr_addr);
      wr_req = 1'b0;
    end
    // run through the second frame's picture, where written bytes appear
    while (k < VT * HT + (TOP + IMG) * HT + 10) @(negedge clk);
    // mid-frame reset, then restart from position 0
    run_chk = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    run_chk = 1'b1;
    repeat (2 * HT) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule